// File: doc/BRIEF.md
# FIFO-Gated Burst Planner

This block decides, for one overlay fetch channel, when a read burst may start on the system bus and what shape that burst takes. Software or a sequencer loads the number of words left in the current line or frame. The planner then compares the local FIFO's free space against a start threshold set by a two-bit burst-length setting. When the threshold is met, it presents one request that carries an AHB HBURST code and a beat count, and holds that request until the bus side acknowledges completion.

Each burst is the largest defined-length burst the setting permits that fits both the words still owed and the FIFO room. A remainder of two or three beats is sent either as one undefined-length INCR or, in defined-length-only mode, as single transfers. During rotated fetches the request can also carry a bus lock, which a disable input suppresses.

Top module: `ahb_burst_planner`

## Requirements
- R1: After reset `req_o` and `hlock_o` are 0 and `remain_o` is 0.
- R2: A request is raised only when `remain_o` is nonzero and `fifo_free_i` is at least the start threshold of `blen_i` (0→1, 1→4, 2→8, 3→16 words). It appears on the clock edge that sees these conditions while `req_o` and `load_i` are low.
- R3: The largest burst per setting is 16 words for settings 0 and 3, 4 words for setting 1 and 8 words for setting 2. With avail = min(remaining, free), the planner picks the largest of 16/8/4 that is within both the cap and avail. HBURST codes: SINGLE 3'b000, INCR 3'b001, INCR4 3'b011, INCR8 3'b101, INCR16 3'b111.
- R4: With `dlbo_i`=0 and an avail of 2 or 3, the planner issues INCR with `beats_o` equal to avail.
- R5: With `dlbo_i`=1 and an avail of 2 or 3, the planner issues SINGLE with 1 beat. It never issues INCR in this mode.
- R6: An avail of 1 gives SINGLE with 1 beat. In setting 0 the burst size follows min(remaining, free) whenever at least one word of space exists.
- R7: `load_i` while `req_o` is low sets `remain_o` to `len_i` on the next edge.
- R8: Only one request is outstanding. `req_o`, `hburst_o` and `beats_o` hold until `done_i` is sampled high. On that edge `req_o` falls and `remain_o` drops by `beats_o`.
- R9: `hlock_o` is high for the whole request when `rot_i`=1 and `lock_dis_i`=0 at issue, and low otherwise. It falls on the edge that accepts `done_i`.
- R10: `load_i` while `req_o` is high is ignored. `remain_o` and the request are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load words-remaining count |
| len_i | input | CNT_W | Words to fetch for the line or frame |
| blen_i | input | 2 | Burst-length setting |
| dlbo_i | input | 1 | Defined-length bursts only |
| rot_i | input | 1 | Rotated fetch in progress |
| lock_dis_i | input | 1 | Suppress bus lock during rotation |
| fifo_free_i | input | FREE_W | FIFO free space in words |
| done_i | input | 1 | Bus side finished the current burst |
| req_o | output | 1 | Burst request pending |
| hburst_o | output | 3 | HBURST code of the request |
| beats_o | output | 5 | Beat count of the request |
| hlock_o | output | 1 | Bus lock for the request |
| remain_o | output | CNT_W | Words still to request |

## Verification
The assertions assume that `done_i` is pulsed only while `req_o` is high, and that `fifo_free_i` and `blen_i` describe the state on the edge where a request is taken. The bench pulses `done_i` for exactly one cycle and only after it has seen `req_o` high. It changes configuration and free space only at falling edges. A sweep covers every setting, both modes, remaining counts of 1 to 20 and free space of 0 to 20. Each result is compared with an arithmetic model of the sizing rule.

// File: rtl/ahb_burst_planner_pkg.sv
package ahb_burst_planner_pkg;
  localparam int BEAT_W = 5;

  typedef enum logic [2:0] {
    HB_SINGLE = 3'b000,
    HB_INCR   = 3'b001,
    HB_INCR4  = 3'b011,
    HB_INCR8  = 3'b101,
    HB_INCR16 = 3'b111
  } hburst_e;

  function automatic logic [BEAT_W-1:0] start_thr(input logic [1:0] blen);
    case (blen)
      2'd0:    return BEAT_W'(1);
      2'd1:    return BEAT_W'(4);
      2'd2:    return BEAT_W'(8);
      default: return BEAT_W'(16);
    endcase
  endfunction

  function automatic logic [BEAT_W-1:0] burst_cap(input logic [1:0] blen);
    case (blen)
      2'd1:    return BEAT_W'(4);
      2'd2:    return BEAT_W'(8);
      default: return BEAT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/burst_sizer.sv
module burst_sizer
  import ahb_burst_planner_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int FREE_W = 6
) (
  input  logic [1:0]        blen_i,
  input  logic              dlbo_i,
  input  logic [CNT_W-1:0]  remain_i,
  input  logic [FREE_W-1:0] free_i,
  output logic              start_ok_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic [2:0]        hburst_o
);
  localparam int AV_W = (CNT_W > FREE_W) ? CNT_W : FREE_W;

  logic [AV_W-1:0]   avail;
  logic [BEAT_W-1:0] cap;

  always_comb begin
    avail = (AV_W'(remain_i) < AV_W'(free_i)) ? AV_W'(remain_i) : AV_W'(free_i);
    cap   = burst_cap(blen_i);
    start_ok_o = (remain_i != '0) && (AV_W'(free_i) >= AV_W'(start_thr(blen_i)));
    if (cap >= BEAT_W'(16) && avail >= AV_W'(16)) begin
      beats_o = BEAT_W'(16); hburst_o = HB_INCR16;
    end else if (cap >= BEAT_W'(8) && avail >= AV_W'(8)) begin
      beats_o = BEAT_W'(8);  hburst_o = HB_INCR8;
    end else if (avail >= AV_W'(4)) begin
      beats_o = BEAT_W'(4);  hburst_o = HB_INCR4;
    end else if (avail >= AV_W'(2) && !dlbo_i) begin
      beats_o = BEAT_W'(avail); hburst_o = HB_INCR;   // short undefined-length tail
    end else begin
      beats_o = BEAT_W'(1);  hburst_o = HB_SINGLE;
    end
  end
endmodule

// File: rtl/word_counter.sv
module word_counter
  import ahb_burst_planner_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              dec_i,
  input  logic [BEAT_W-1:0] dec_amt_i,
  output logic [CNT_W-1:0]  remain_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     remain_o <= '0;
    else if (load_i) remain_o <= len_i;
    else if (dec_i)  remain_o <= remain_o - CNT_W'(dec_amt_i);
  end
endmodule

// File: rtl/req_ctrl.sv
module req_ctrl
  import ahb_burst_planner_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              done_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic [2:0]        hburst_i,
  input  logic              lock_i,
  output logic              req_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic [2:0]        hburst_o,
  output logic              hlock_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o    <= 1'b0;
      beats_o  <= '0;
      hburst_o <= HB_SINGLE;
      lock_q   <= 1'b0;
    end else if (req_o) begin
      if (done_i) begin
        req_o  <= 1'b0;
        lock_q <= 1'b0;
      end
    end else if (go_i) begin
      req_o    <= 1'b1;
      beats_o  <= beats_i;
      hburst_o <= hburst_i;
      lock_q   <= lock_i;
    end
  end

  assign hlock_o = req_o & lock_q;
endmodule

// File: rtl/ahb_burst_planner.sv
module ahb_burst_planner
  import ahb_burst_planner_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int FREE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [1:0]        blen_i,
  input  logic              dlbo_i,
  input  logic              rot_i,
  input  logic              lock_dis_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  input  logic              done_i,
  output logic              req_o,
  output logic [2:0]        hburst_o,
  output logic [4:0]        beats_o,
  output logic              hlock_o,
  output logic [CNT_W-1:0]  remain_o
);
  logic              start_ok;
  logic [BEAT_W-1:0] next_beats;
  logic [2:0]        next_hburst;
  logic              go, load_ok, dec;

  assign load_ok = load_i & ~req_o;
  assign go      = start_ok & ~req_o & ~load_i;
  assign dec     = req_o & done_i;

  burst_sizer #(.CNT_W(CNT_W), .FREE_W(FREE_W)) i_sizer (
    .blen_i     (blen_i),
    .dlbo_i     (dlbo_i),
    .remain_i   (remain_o),
    .free_i     (fifo_free_i),
    .start_ok_o (start_ok),
    .beats_o    (next_beats),
    .hburst_o   (next_hburst)
  );

  word_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_ok),
    .len_i     (len_i),
    .dec_i     (dec),
    .dec_amt_i (beats_o),
    .remain_o  (remain_o)
  );

  req_ctrl i_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .done_i   (done_i),
    .beats_i  (next_beats),
    .hburst_i (next_hburst),
    .lock_i   (rot_i & ~lock_dis_i),
    .req_o    (req_o),
    .beats_o  (beats_o),
    .hburst_o (hburst_o),
    .hlock_o  (hlock_o)
  );
endmodule

// File: rtl/ahb_burst_planner_chk.sv
module ahb_burst_planner_chk
  import ahb_burst_planner_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int FREE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [1:0]        blen_i,
  input logic              dlbo_i,
  input logic [FREE_W-1:0] fifo_free_i,
  input logic              done_i,
  input logic              req_o,
  input logic [2:0]        hburst_o,
  input logic [4:0]        beats_o,
  input logic              hlock_o,
  input logic [CNT_W-1:0]  remain_o
);
  localparam int AV_W = (CNT_W > FREE_W) ? CNT_W : FREE_W;

  assert_start_thr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> AV_W'($past(fifo_free_i)) >= AV_W'(start_thr($past(blen_i))));

  assert_code_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((hburst_o == 3'b111 && beats_o == 5'd16) || (hburst_o == 3'b101 && beats_o == 5'd8) ||
               (hburst_o == 3'b011 && beats_o == 5'd4)  || (hburst_o == 3'b001 && (beats_o == 5'd2 || beats_o == 5'd3)) ||
               (hburst_o == 3'b000 && beats_o == 5'd1)));

  assert_no_incr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_o) && $past(dlbo_i)) |-> hburst_o != 3'b001);

  assert_within_remain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> CNT_W'(beats_o) <= remain_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i) |=> req_o && $stable(hburst_o) && $stable(beats_o) && $stable(remain_o));

  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && done_i) |=> !req_o && !hlock_o);

  assert_lock_in_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlock_o |-> req_o);

  assert_load_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && load_i && !done_i) |=> remain_o == $past(remain_o));
endmodule

bind ahb_burst_planner ahb_burst_planner_chk #(.CNT_W(CNT_W), .FREE_W(FREE_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .blen_i      (blen_i),
  .dlbo_i      (dlbo_i),
  .fifo_free_i (fifo_free_i),
  .done_i      (done_i),
  .req_o       (req_o),
  .hburst_o    (hburst_o),
  .beats_o     (beats_o),
  .hlock_o     (hlock_o),
  .remain_o    (remain_o)
);

// File: tb/test_ahb_burst_planner.sv
module test_ahb_burst_planner;
  localparam int CNT_W = 12;
  localparam int FREE_W = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic load_i = 0, dlbo_i = 0, rot_i = 0, lock_dis_i = 0, done_i = 0;
  logic [CNT_W-1:0] len_i = '0;
  logic [1:0] blen_i = '0;
  logic [FREE_W-1:0] fifo_free_i = '0;
  logic req_o, hlock_o;
  logic [2:0] hburst_o;
  logic [4:0] beats_o;
  logic [CNT_W-1:0] remain_o;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  ahb_burst_planner #(.CNT_W(CNT_W), .FREE_W(FREE_W)) i_ahb_burst_planner (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .len_i(len_i), .blen_i(blen_i),
    .dlbo_i(dlbo_i), .rot_i(rot_i), .lock_dis_i(lock_dis_i), .fifo_free_i(fifo_free_i),
    .done_i(done_i), .req_o(req_o), .hburst_o(hburst_o), .beats_o(beats_o),
    .hlock_o(hlock_o), .remain_o(remain_o));

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int thr(input int b);
    return (b == 0) ? 1 : (b == 1) ? 4 : (b == 2) ? 8 : 16;
  endfunction

  // expected {code, beats}
  task automatic model(input int b, input int d, input int rem, input int fr,
                       output int code, output int nb);
    int cap = (b == 1) ? 4 : (b == 2) ? 8 : 16;
    int av = (rem < fr) ? rem : fr;
    if (cap >= 16 && av >= 16) begin code = 7; nb = 16; end
    else if (cap >= 8 && av >= 8) begin code = 5; nb = 8; end
    else if (av >= 4) begin code = 3; nb = 4; end
    else if (av >= 2 && d == 0) begin code = 1; nb = av; end
    else begin code = 0; nb = 1; end
  endtask

  task automatic load_len(input int n);
    @(negedge clk); len_i = CNT_W'(n); load_i = 1; fifo_free_i = '0;
    @(negedge clk); load_i = 0;
    chk("R7 load", int'(remain_o), n);
  endtask

  task automatic finish_req(input int exp_rem);
    done_i = 1;
    @(negedge clk); done_i = 0; fifo_free_i = '0;
    chk("R8 req drop", int'(req_o), 0);
    chk("R8 remain after done", int'(remain_o), exp_rem);
    chk("R9 lock drop", int'(hlock_o), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int code, nb;
    #5;
    chk("R1 req reset", int'(req_o), 0);
    chk("R1 lock reset", int'(hlock_o), 0);
    chk("R1 remain reset", int'(remain_o), 0);
    @(negedge clk); rst_ni = 1;

    // R2 R3 R4 R5 R6 sweep
    for (int b = 0; b < 4; b++)
      for (int d = 0; d < 2; d++)
        for (int rem = 1; rem <= 20; rem++)
          for (int fr = 0; fr <= 20; fr++) begin
            blen_i = 2'(b); dlbo_i = d[0];
            load_len(rem);
            fifo_free_i = FREE_W'(fr);
            @(negedge clk);
            if (fr < thr(b)) chk("R2 no start", int'(req_o), 0);
            else begin
              model(b, d, rem, fr, code, nb);
              chk("R2 start", int'(req_o), 1);
              chk(d ? "R5 code" : "R3 R4 R6 code", int'(hburst_o), code);
              chk(d ? "R5 beats" : "R3 R4 R6 beats", int'(beats_o), nb);
              finish_req(rem - nb);
            end
          end

    // R8: drain 23 words, setting 3, INCR tails
    blen_i = 2'd3; dlbo_i = 0;
    load_len(23);
    begin
      int rem = 23, guard = 0;
      while (rem > 0 && guard < 10) begin
        fifo_free_i = 6'd63;
        @(negedge clk);
        model(3, 0, rem, 63, code, nb);
        chk("R8 drain req", int'(req_o), 1);
        chk("R8 drain code", int'(hburst_o), code);
        chk("R8 drain beats", int'(beats_o), nb);
        rem -= nb;
        finish_req(rem);
        guard++;
      end
      chk("R8 drain bursts", guard, 3);
    end

    // R10 + R8 hold: load ignored during request, fields held
    blen_i = 2'd1; load_len(10);
    fifo_free_i = 6'd20;
    @(negedge clk);
    chk("R8 issue", int'(hburst_o), 3);
    fifo_free_i = '0; len_i = 12'd3; load_i = 1;
    @(negedge clk); load_i = 0;
    chk("R10 remain kept", int'(remain_o), 10);
    @(negedge clk); @(negedge clk);
    chk("R8 held req", int'(req_o), 1);
    chk("R8 held beats", int'(beats_o), 4);
    finish_req(6);

    // R9 lock matrix
    for (int r = 0; r < 2; r++)
      for (int l = 0; l < 2; l++) begin
        blen_i = 2'd2; rot_i = r[0]; lock_dis_i = l[0];
        load_len(8);
        fifo_free_i = 6'd8;
        @(negedge clk);
        chk("R9 lock", int'(hlock_o), (r == 1 && l == 0) ? 1 : 0);
        @(negedge clk);
        chk("R9 lock held", int'(hlock_o), (r == 1 && l == 0) ? 1 : 0);
        finish_req(0);
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule